// File: doc/BRIEF.md
# Legacy Shadow Window Route Decoder

This block sits in the memory path of a PC-style host bridge. It decides, for each CPU access, whether the access goes to main DRAM or to the firmware/ROM side. Its decisions cover the upper part of the legacy first megabyte, from 0xC0000 to 0xFFFFF. That window is split into fourteen attribute slots. Each slot carries one 4-bit field, and the fields live in seven byte-wide configuration registers. In each field, one bit lets reads reach DRAM and another bit lets writes reach DRAM. The two controls are independent, so firmware can copy its image into DRAM (writes on, reads off) and later run from DRAM (reads on, writes off).

The firmware image is also decoded at the top of the 4 GB space, where its last byte sits at 0xFFFFFFFF. Its last min(image size, 128 KB) bytes also appear ending at 0xFFFFF whenever the legacy window routes an access to ROM. For each routed access the block reports the offset into the image.

Accesses come in on a valid/ready stream and results leave on another. The decoder takes an access when `acc_valid` and `acc_ready` are both high. `acc_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure on `rt_ready` stalls the input. The configuration port is a plain byte port: a write strobe and an address, with the readback taken combinationally.

Top module: `shdw_decoder`

## Requirements
- R1: After reset, all seven attribute registers read 0x00, and every access in 0xC0000–0xFFFFF is routed to ROM.
- R2: The attribute registers answer at config offsets 0x59–0x5F. Slot n lives in register 0x59 + n/2: an even n uses bits [3:0] and an odd n uses bits [7:4]. Every other offset reads 0x00 and ignores writes.
- R3: A read in a legacy slot goes to DRAM (`rt_dram`=1) when the slot's bit 0 (read-enable) is 1. Otherwise it goes to ROM (`rt_rom`=1), whatever bit 1 holds.
- R4: A write in a legacy slot goes to DRAM with `rt_store`=1 when the slot's bit 1 (write-enable) is 1. Otherwise it goes to ROM with `rt_store`=0, so the write is dropped. `rt_store` is never 1 on the ROM route.
- R5: The slots map to addresses as follows. Slot 1 covers 0xF0000–0xFFFFF. Slots 2..9 cover 16 KB steps from 0xC0000 to 0xDFFFF. Slots 10..13 cover 16 KB steps from 0xE0000 to 0xEFFFF. Slot 0 decodes no address.
- R6: Any address outside 0xC0000–0xFFFFF and outside the top firmware window routes to DRAM, and a write there has `rt_store`=1, whatever the attributes hold.
- R7: An address at or above 2^32 − 2^IMG_AW (0xFFFF0000 by default) routes to ROM with `rt_img_hit`=1, `rt_img_off` = address − window base, and `rt_store`=0.
- R8: A ROM-routed legacy access in the last min(2^IMG_AW, 128 KB) bytes below 0x100000 has `rt_img_hit`=1 and an offset placing 0xFFFFF at the image's last byte. By default, offset = address − 0xF0000. Lower ROM-routed legacy addresses have `rt_img_hit`=0.
- R9: A config write takes effect from the cycle after its strobe. An access accepted in the same cycle as the write uses the old attributes.
- R10: The result appears one cycle after acceptance and holds steady while `rt_ready` is low. `acc_ready` = !`rt_valid` | `rt_ready`. A held result keeps the route it was given at acceptance, even if the attributes change afterwards.
- R11: While `rt_valid` is 1, exactly one of `rt_dram` and `rt_rom` is 1. `rt_addr` and `rt_write` echo the accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config byte write strobe |
| cfg_addr | input | 8 | Config offset for write and readback |
| cfg_wdata | input | 8 | Config write byte |
| cfg_rdata | output | 8 | Config readback at cfg_addr |
| acc_valid | input | 1 | CPU access present |
| acc_ready | output | 1 | Decoder can take the access |
| acc_addr | input | 32 | CPU byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| rt_valid | output | 1 | Route result present |
| rt_ready | input | 1 | Downstream takes the result |
| rt_addr | output | 32 | Address of the routed access |
| rt_write | output | 1 | Routed access is a write |
| rt_dram | output | 1 | DRAM select |
| rt_rom | output | 1 | ROM select |
| rt_store | output | 1 | Write is committed to DRAM |
| rt_img_hit | output | 1 | ROM access is backed by the firmware image |
| rt_img_off | output | IMG_AW | Byte offset into the firmware image |

## Verification
The hardest case to reach from the ports is a config write that lands in the same cycle as an access to the slot it changes. A close second is an attribute change while a result sits stalled in the output register. The bench raises the write strobe and the access valid at the same clock edge and expects the old route, then repeats the access and expects the new one. For the stall case, it drops `rt_ready`, lets one access be taken, and rewrites that slot's attributes during the stall. It then releases the stall and checks that the held result still shows the route chosen at acceptance.

// File: rtl/shdw_pkg.sv
package shdw_pkg;
  // Geometry of the legacy window
  localparam int SLOT_CNT   = 14;
  localparam int REG_CNT    = SLOT_CNT / 2;
  localparam int SLOT_W     = 4;
  localparam logic [7:0] CFG_FIRST = 8'h59;
  localparam logic [7:0] CFG_LAST  = CFG_FIRST + 8'(REG_CNT - 1);

  // Attribute bit positions inside a slot field
  localparam int BIT_RD = 0;
  localparam int BIT_WR = 1;

  // Address class of an access
  typedef enum logic [1:0] {
    RGN_PLAIN  = 2'd0,
    RGN_LEGACY = 2'd1,
    RGN_TOPFW  = 2'd2
  } rgn_e;
endpackage

// File: rtl/shdw_attr_regs.sv
module shdw_attr_regs
  import shdw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [7:0]          cfg_addr,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  output logic [SLOT_CNT-1:0] slot_rd_en,
  output logic [SLOT_CNT-1:0] slot_wr_en
);
  localparam int IDX_W = $clog2(REG_CNT);

  logic [7:0]       regs_q [REG_CNT];
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [7:0]       ofs;

  assign ofs = cfg_addr - CFG_FIRST;
  assign hit = (cfg_addr >= CFG_FIRST) && (cfg_addr <= CFG_LAST);
  assign idx = ofs[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_CNT; i++) regs_q[i] <= 8'h00;
    end else if (cfg_we && hit) begin
      regs_q[idx] <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (hit) cfg_rdata = regs_q[idx];
  end

  // Even slots sit in the low nibble, odd slots in the high nibble
  for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
    localparam int LSB = (s % 2) * SLOT_W;
    assign slot_rd_en[s] = regs_q[s/2][LSB + BIT_RD];
    assign slot_wr_en[s] = regs_q[s/2][LSB + BIT_WR];
  end
endmodule

// File: rtl/shdw_addr_decode.sv
module shdw_addr_decode
  import shdw_pkg::*;
#(
  parameter int IMG_AW = 16
) (
  input  logic [31:0]       addr,
  output rgn_e              rgn,
  output logic [3:0]        slot,
  output logic              alias_hit,
  output logic [IMG_AW-1:0] img_off
);
  localparam int ALIAS_AW = (IMG_AW < 17) ? IMG_AW : 17;

  logic in_legacy;
  logic in_top;
  logic [IMG_AW-1:0] alias_off;

  assign in_legacy = (addr[31:20] == 12'h000) && (&addr[19:18]);
  assign in_top    = &addr[31:IMG_AW];

  always_comb begin
    if (in_top)         rgn = RGN_TOPFW;
    else if (in_legacy) rgn = RGN_LEGACY;
    else                rgn = RGN_PLAIN;
  end

  // 64 KB slot 1 at 0xF0000, 16 KB slots 2..13 from 0xC0000 upward
  always_comb begin
    if (addr[19:16] == 4'hF) slot = 4'd1;
    else                     slot = 4'd2 + addr[17:14];
  end

  // The alias ends at 0xFFFFF; it spans the image or 128 KB, whichever is smaller
  if (IMG_AW <= ALIAS_AW) begin : g_whole_img
    assign alias_hit = in_legacy && (&addr[19:IMG_AW]);
    assign alias_off = addr[IMG_AW-1:0];
  end else begin : g_img_tail
    assign alias_hit = in_legacy && (&addr[19:ALIAS_AW]);
    assign alias_off = {{(IMG_AW-ALIAS_AW){1'b1}}, addr[ALIAS_AW-1:0]};
  end

  always_comb begin
    if (in_top)         img_off = addr[IMG_AW-1:0];
    else if (alias_hit) img_off = alias_off;
    else                img_off = '0;
  end
endmodule

// File: rtl/shdw_route_stage.sv
module shdw_route_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic          vld_q;
  logic [PW-1:0] dat_q;
  logic          take;

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (take) begin
      vld_q <= 1'b1;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dat_q <= '0;
    else if (take) dat_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/shdw_decoder.sv
module shdw_decoder
  import shdw_pkg::*;
#(
  parameter int IMG_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [31:0]       acc_addr,
  input  logic              acc_write,
  output logic              rt_valid,
  input  logic              rt_ready,
  output logic [31:0]       rt_addr,
  output logic              rt_write,
  output logic              rt_dram,
  output logic              rt_rom,
  output logic              rt_store,
  output logic              rt_img_hit,
  output logic [IMG_AW-1:0] rt_img_off
);
  localparam int PW = 32 + 5 + IMG_AW;

  logic [SLOT_CNT-1:0] rd_en;
  logic [SLOT_CNT-1:0] wr_en;
  rgn_e                rgn;
  logic [3:0]          slot;
  logic                alias_hit;
  logic [IMG_AW-1:0]   img_off;
  logic                slot_rd;
  logic                slot_wr;
  logic                to_dram;
  logic                img_hit;
  logic [PW-1:0]       pay_in;
  logic [PW-1:0]       pay_out;

  shdw_attr_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .slot_rd_en (rd_en),
    .slot_wr_en (wr_en)
  );

  shdw_addr_decode #(.IMG_AW(IMG_AW)) u_dec (
    .addr      (acc_addr),
    .rgn       (rgn),
    .slot      (slot),
    .alias_hit (alias_hit),
    .img_off   (img_off)
  );

  // Pick the attribute pair of the addressed slot
  always_comb begin
    slot_rd = 1'b0;
    slot_wr = 1'b0;
    for (int i = 0; i < SLOT_CNT; i++) begin
      if (slot == 4'(i)) begin
        slot_rd = rd_en[i];
        slot_wr = wr_en[i];
      end
    end
  end

  always_comb begin
    unique case (rgn)
      RGN_TOPFW:  to_dram = 1'b0;
      RGN_LEGACY: to_dram = acc_write ? slot_wr : slot_rd;
      default:    to_dram = 1'b1;
    endcase
  end

  assign img_hit = !to_dram && ((rgn == RGN_TOPFW) || alias_hit);

  assign pay_in = {acc_addr, acc_write, to_dram, !to_dram,
                   acc_write && to_dram, img_hit,
                   img_hit ? img_off : {IMG_AW{1'b0}}};

  shdw_route_stage #(.PW(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (acc_valid),
    .in_ready  (acc_ready),
    .in_data   (pay_in),
    .out_valid (rt_valid),
    .out_ready (rt_ready),
    .out_data  (pay_out)
  );

  assign {rt_addr, rt_write, rt_dram, rt_rom, rt_store, rt_img_hit, rt_img_off} = pay_out;
endmodule

// File: rtl/shdw_decoder_chk.sv
module shdw_decoder_chk #(
  parameter int IMG_AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [31:0]       acc_addr,
  input logic              rt_valid,
  input logic              rt_ready,
  input logic [31:0]       rt_addr,
  input logic              rt_write,
  input logic              rt_dram,
  input logic              rt_rom,
  input logic              rt_store,
  input logic              rt_img_hit,
  input logic [IMG_AW-1:0] rt_img_off
);
  logic out_top;
  logic out_legacy;
  assign out_top    = &rt_addr[31:IMG_AW];
  assign out_legacy = (rt_addr[31:20] == 12'h000) && (&rt_addr[19:18]);

  assert_one_route_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |-> $countones({rt_dram, rt_rom}) == 1);

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && !rt_ready |=> rt_valid && $stable(rt_addr) && $stable(rt_dram)
                              && $stable(rt_store) && $stable(rt_img_off));

  assert_echo_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready |=> rt_valid && rt_addr == $past(acc_addr));

  assert_store_dram_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && rt_store |-> rt_dram && rt_write);

  assert_plain_dram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && !out_top && !out_legacy |-> rt_dram && (rt_store == rt_write));

  assert_top_rom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && out_top |-> rt_rom && rt_img_hit && !rt_store
                            && rt_img_off == rt_addr[IMG_AW-1:0]);
endmodule

bind shdw_decoder shdw_decoder_chk #(.IMG_AW(IMG_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .acc_addr   (acc_addr),
  .rt_valid   (rt_valid),
  .rt_ready   (rt_ready),
  .rt_addr    (rt_addr),
  .rt_write   (rt_write),
  .rt_dram    (rt_dram),
  .rt_rom     (rt_rom),
  .rt_store   (rt_store),
  .rt_img_hit (rt_img_hit),
  .rt_img_off (rt_img_off)
);

// File: tb/tb_shdw_decoder.sv
module tb_shdw_decoder;
  localparam int IMG_AW = 16;
  localparam logic [31:0] IMG_SZ = 32'h1 << IMG_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic acc_valid = 1'b0;
  logic acc_ready;
  logic [31:0] acc_addr = '0;
  logic acc_write = 1'b0;
  logic rt_valid;
  logic rt_ready = 1'b1;
  logic [31:0] rt_addr;
  logic rt_write, rt_dram, rt_rom, rt_store, rt_img_hit;
  logic [IMG_AW-1:0] rt_img_off;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  shdw_decoder #(.IMG_AW(IMG_AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_addr(acc_addr), .acc_write(acc_write),
    .rt_valid(rt_valid), .rt_ready(rt_ready), .rt_addr(rt_addr),
    .rt_write(rt_write), .rt_dram(rt_dram), .rt_rom(rt_rom),
    .rt_store(rt_store), .rt_img_hit(rt_img_hit), .rt_img_off(rt_img_off)
  );

  typedef struct {
    logic [31:0] addr;
    logic wr, dram, store, hit;
    logic [IMG_AW-1:0] off;
    string req;
  } item_t;

  item_t sb_q[$];
  logic [7:0] shadow [7];

  function automatic item_t model(logic [31:0] a, logic wr, string req);
    item_t it;
    int slot;
    logic [3:0] nib;
    it.addr = a; it.wr = wr; it.req = req; it.hit = 0; it.off = '0;
    if (a >= 32'hFFFF_FFFF - IMG_SZ + 1) begin
      it.dram = 0; it.hit = 1; it.off = IMG_AW'(a - (32'hFFFF_FFFF - IMG_SZ + 1));
    end else if (a >= 32'hC0000 && a <= 32'hFFFFF) begin
      slot = (a >= 32'hF0000) ? 1 : 2 + int'((a - 32'hC0000) / 32'h4000);
      nib  = (slot % 2 == 1) ? shadow[slot/2][7:4] : shadow[slot/2][3:0];
      it.dram = wr ? nib[1] : nib[0];
      if (!it.dram && a >= 32'h100000 - IMG_SZ) begin
        it.hit = 1; it.off = IMG_AW'(a - (32'h100000 - IMG_SZ));
      end
    end else begin
      it.dram = 1;
    end
    it.store = wr && it.dram;
    return it;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a >= 8'h59 && a <= 8'h5F) shadow[a - 8'h59] = d;
  endtask

  task automatic cfg_check(logic [7:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(cfg_rdata == exp, req, "cfg readback", 64'(cfg_rdata), 64'(exp));
  endtask

  // Driver: push the expected route, then hand the access over
  task automatic send(logic [31:0] a, logic wr, string req);
    @(negedge clk);
    sb_q.push_back(model(a, wr, req));
    acc_valid = 1; acc_addr = a; acc_write = wr;
    #1;
    while (!acc_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    acc_valid = 0;
  endtask

  // Monitor: compare every completed handshake against the queue head
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && rt_valid && rt_ready) begin
        if (sb_q.size() == 0) begin
          check(0, "R10", "unexpected result", 64'(rt_addr), 0);
        end else begin
          item_t e;
          e = sb_q.pop_front();
          check(rt_addr == e.addr && rt_write == e.wr, e.req, "addr/write echo",
                64'(rt_addr), 64'(e.addr));
          check(rt_dram == e.dram && rt_rom == !e.dram, e.req, "route dram/rom",
                64'({rt_dram, rt_rom}), 64'({e.dram, !e.dram}));
          check(rt_store == e.store, e.req, "store", 64'(rt_store), 64'(e.store));
          check(rt_img_hit == e.hit && rt_img_off == e.off, e.req, "image hit/offset",
                64'({rt_img_hit, rt_img_off}), 64'({e.hit, e.off}));
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state of all registers and of the legacy route
    for (int i = 0; i < 7; i++) cfg_check(8'h59 + 8'(i), 8'h00, "R1");
    send(32'hC0000, 0, "R1");
    send(32'hFFFFF, 1, "R1");

    // R2: offsets outside 0x59..0x5F read zero and ignore writes
    cfg_write(8'h58, 8'hFF);
    cfg_write(8'h60, 8'hFF);
    cfg_check(8'h58, 8'h00, "R2");
    cfg_check(8'h60, 8'h00, "R2");
    cfg_check(8'h59, 8'h00, "R2");
    send(32'hF4000, 0, "R2");

    // R2/R3/R4/R5: 0x5A low nibble = slot 2 (RE), high = slot 3 (WE)
    cfg_write(8'h5A, 8'h21);
    cfg_check(8'h5A, 8'h21, "R2");
    send(32'hC0000, 0, "R3");
    send(32'hC3FFF, 1, "R4");
    send(32'hC4000, 0, "R3");
    send(32'hC7FFF, 1, "R4");
    send(32'hC8000, 0, "R5");

    // R5/R8: slot 1 occupies 0x59 high nibble, slot 0 decodes nothing
    cfg_write(8'h59, 8'h30);
    send(32'hFFFFF, 0, "R5");
    send(32'hF8000, 1, "R5");
    cfg_write(8'h59, 8'h03);
    send(32'hF0000, 0, "R8");
    send(32'hFFFFF, 0, "R8");
    send(32'hF1234, 1, "R8");

    // R5/R8: slots 9..13; ROM-routed E segment lies below the alias
    cfg_write(8'h5D, 8'h10);
    send(32'hDC000, 0, "R5");
    send(32'hD8000, 0, "R5");
    cfg_write(8'h5E, 8'h01);
    send(32'hE0000, 0, "R5");
    send(32'hE4000, 0, "R8");
    cfg_write(8'h5F, 8'h20);
    send(32'hEC000, 1, "R5");
    send(32'hE8000, 1, "R4");

    // R6: addresses outside both windows always reach DRAM
    cfg_write(8'h59, 8'h00);
    send(32'h0009FFFF, 1, "R6");
    send(32'h00100000, 0, "R6");
    send(32'h7FFF0000, 1, "R6");
    send(32'hFFFEFFFF, 0, "R6");

    // R7: top firmware window
    send(32'hFFFF0000, 0, "R7");
    send(32'hFFFFFFFF, 1, "R7");
    send(32'hFFFF8001, 0, "R7");

    // R9: config write and access in the same cycle use the old attributes
    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'h5B; cfg_wdata = 8'h01;   // slot 4 RE
    sb_q.push_back(model(32'hC8000, 0, "R9"));
    acc_valid = 1; acc_addr = 32'hC8000; acc_write = 0;
    @(negedge clk);
    cfg_we = 0; acc_valid = 0;
    shadow[2] = 8'h01;
    send(32'hC8000, 0, "R9");

    // R10: stalled result keeps the route chosen at acceptance
    @(negedge clk);
    rt_ready = 0;
    send(32'hC8000, 0, "R10");
    cfg_write(8'h5B, 8'h00);
    #1;
    check(acc_ready == 0, "R10", "acc_ready during stall", 64'(acc_ready), 0);
    check(rt_valid == 1 && rt_dram == 1, "R10", "held route", 64'({rt_valid, rt_dram}), 64'h3);
    repeat (3) @(negedge clk);
    rt_ready = 1;
    send(32'hC8000, 0, "R10");

    repeat (5) @(negedge clk);
    check(sb_q.size() == 0, "R11", "scoreboard drained", 64'(sb_q.size()), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule